// File: doc/BRIEF.md
# Tunable Digital Down Converter

This block takes a stream of real signed 8-bit IF samples. It shifts one chosen frequency of that band down to zero and returns a decimated complex baseband stream. A 30-bit phase accumulator runs at the 2^30 Hz sample rate, so one unit of the tuning word equals exactly 1 Hz of oscillator frequency. The top ten phase bits address a quarter-wave sine table. The mixer forms the in-phase and quadrature products by summing shifted copies of the sample, selected by the bits of the table magnitude, so no hardware multiplier is used. Each path then enters a four-stage cascaded integrator-comb decimator. Its ratio is chosen at run time from a power-of-two ladder, so the complex output rate steps down in halves from about 16 MHz to about 0.25 MHz.

Software-style writes set the tuning word, the bandwidth code and the sideband. Written values wait in a pending set. They become active only when the decimator completes an output sample. A change of bandwidth at that point clears the decimator.

A controller sequences this work with three states:
- `ST_IDLE`: reached at reset. Here pending settings pass straight to the active set. The first accepted sample moves the controller to `ST_PRIME`.
- `ST_PRIME`: decimated results are computed but withheld while the filter refills. After four output boundaries without a bandwidth change, the controller moves to `ST_RUN`. A boundary with a bandwidth change restarts `ST_PRIME`.
- `ST_RUN`: every output boundary emits a sample. A boundary that brings a bandwidth change flushes the filter and returns the controller to `ST_PRIME`.

Top module: `ddc_tunable`

## Requirements
- R1: While reset is asserted, and on the cycle after reset is released, `out_valid` is 0 and `out_i` and `out_q` are 0.
- R2: The phase accumulator is 30 bits wide and wraps modulo 2^30. It advances by the active tuning word on each accepted sample and holds otherwise, so the oscillator runs at (tuning word) Hz for a 2^30 Hz sample rate. Idle cycles between samples do not change any result.
- R3: Sine is read from phase bits [29:20] through a quarter-wave table with amplitude 127. Cosine reads the same table 256 entries later. So at 0, 90, 180 and 270 degrees, cosine is 127, 0, −127, 0 and sine is 0, 127, 0, −127.
- R4: The mixer produces I = x·cos and Q = −x·sin as signed products by adding shifted copies of x. Their magnitude never exceeds 128·127.
- R5: Bandwidth code k (0 to 6) selects decimation ratio 64·2^k. Codes 7 act as 6. The four-stage decimator has unity DC gain after rounding to 16 bits, so a steady mixer value m gives exactly m at the output.
- R6: `out_valid` is a single-cycle pulse one clock after the sample that completes each block of 64·2^k accepted samples.
- R7: When the sideband bit is 1, the sign of the Q output is inverted. I is unchanged.
- R8: A write with `cfg_we` stores `cfg_wdata[29:0]` as the tuning word at address 0, `cfg_wdata[2:0]` as the bandwidth code at address 1, and `cfg_wdata[0]` as the sideband bit at address 2. Writes to address 3 are ignored. A stored value becomes active at the next output boundary; before the first sample it becomes active at once.
- R9: A bandwidth change clears the decimator at the boundary where it becomes active, and the next four outputs are withheld. The first output after reset, or after such a change, therefore appears 5·64·2^k samples later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept `in_data` on this clock |
| in_data | input | 8 | Signed IF sample |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting select: 0 tuning, 1 bandwidth, 2 sideband |
| cfg_wdata | input | 32 | Setting value |
| out_valid | output | 1 | Baseband sample strobe |
| out_i | output | 16 | Signed in-phase output |
| out_q | output | 16 | Signed quadrature output |

## Verification
The assertions assume that the bandwidth code reaching the decimator is at most 6, which the clamp at the write port guarantees. They also assume that output boundaries are at least 64 samples apart, which is the basis of the single-pulse check. The exact-value checks rest on stimulus that the bench keeps inside a narrow class. Every sample pattern has period four, and the tuning words are 0, a quarter, a half or three quarters of the sample rate. Each decimator window therefore averages a whole number of periods, and every expected output is an exact integer. The bench resets before each table entry so that the phase starts at zero, and it reads outputs only after the filter has refilled.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    localparam int SAMPLE_BITS    = 8;
    localparam int PHASE_BITS     = 30;
    localparam int LUT_ADDR_BITS  = 10;
    localparam int COEF_BITS      = 8;
    localparam int MIX_BITS       = 16;
    localparam int CIC_STAGES     = 4;
    localparam int BASE_RATIO_LOG = 6;
    localparam int CODE_TOP       = 6;
    localparam int OUT_BITS       = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } ddc_state_t;

    typedef struct packed {
        logic [PHASE_BITS-1:0] tune;
        logic [2:0]            bw;
        logic                  lsb;
    } ddc_cfg_t;

    // Rational sine approximation on a quarter wave, evaluated at elaboration.
    function automatic int quarter_sine(input int j, input int half_n, input int amp);
        longint num;
        longint den;
        num = longint'(amp) * 16 * longint'(j) * longint'(half_n - j);
        den = 5 * longint'(half_n) * longint'(half_n) - 4 * longint'(j) * longint'(half_n - j);
        return int'((num + den / 2) / den);
    endfunction

endpackage

// File: rtl/ddc_nco.sv
module ddc_nco
    import ddc_pkg::*;
#(
    parameter int PHASE_W = PHASE_BITS,
    parameter int ADDR_W  = LUT_ADDR_BITS,
    parameter int COEF_W  = COEF_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_en,
    input  logic [PHASE_W-1:0]       tune,
    output logic signed [COEF_W-1:0] sin_o,
    output logic signed [COEF_W-1:0] cos_o
);
    localparam int QTR = 2 ** (ADDR_W - 2);
    localparam int AMP = 2 ** (COEF_W - 1) - 1;

    logic [PHASE_W-1:0] phase;
    logic [COEF_W-1:0]  qtab [QTR+1];
    logic [ADDR_W-1:0]  sin_idx;
    logic [ADDR_W-1:0]  cos_idx;

    for (genvar j = 0; j <= QTR; j++) begin : g_qtab
        assign qtab[j] = COEF_W'(quarter_sine(j, 2 * QTR, AMP));
    end

    function automatic logic signed [COEF_W-1:0] look(input logic [ADDR_W-1:0] idx);
        logic [ADDR_W-2:0]        j;
        logic signed [COEF_W-1:0] mag;
        j   = idx[ADDR_W-2] ? ((ADDR_W-1)'(QTR) - {1'b0, idx[ADDR_W-3:0]})
                            : {1'b0, idx[ADDR_W-3:0]};
        mag = signed'(qtab[j]);
        return idx[ADDR_W-1] ? -mag : mag;
    endfunction

    assign sin_idx = phase[PHASE_W-1 -: ADDR_W];
    assign cos_idx = sin_idx + ADDR_W'(QTR);

    always_comb begin
        sin_o = look(sin_idx);
        cos_o = look(cos_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (step_en) begin
            phase <= phase + tune;
        end
    end

    // R2: the accumulator moves only on accepted samples
    a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(phase));

endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer
    import ddc_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_BITS,
    parameter int COEF_W   = COEF_BITS,
    parameter int MIX_W    = MIX_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] x,
    input  logic signed [COEF_W-1:0]   cos_c,
    input  logic signed [COEF_W-1:0]   sin_c,
    output logic signed [MIX_W-1:0]    mix_i,
    output logic signed [MIX_W-1:0]    mix_q
);
    localparam int AMP = 2 ** (COEF_W - 1) - 1;
    localparam int LIM = (2 ** (SAMPLE_W - 1)) * AMP;

    // Product built from shifted copies of x picked by coefficient magnitude bits.
    function automatic logic signed [MIX_W-1:0] lut_prod(
        input logic signed [SAMPLE_W-1:0] xs,
        input logic signed [COEF_W-1:0]   c
    );
        logic [COEF_W-1:0]       mag;
        logic signed [MIX_W-1:0] xe;
        logic signed [MIX_W-1:0] acc;
        mag = c[COEF_W-1] ? unsigned'(-c) : unsigned'(c);
        xe  = MIX_W'(xs);
        acc = '0;
        for (int b = 0; b < COEF_W - 1; b++) begin
            if (mag[b]) acc = acc + (xe <<< b);
        end
        return c[COEF_W-1] ? -acc : acc;
    endfunction

    always_comb begin
        mix_i = lut_prod(x, cos_c);
        mix_q = -lut_prod(x, sin_c);
    end

    // R4: products stay inside the range of an 8-bit sample times 127
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r4_product_range: assert (mix_i <= LIM && mix_i >= -LIM &&
                                        mix_q <= LIM && mix_q >= -LIM);
        end
    end

endmodule

// File: rtl/ddc_cic.sv
module ddc_cic
    import ddc_pkg::*;
#(
    parameter int IN_W      = MIX_BITS,
    parameter int STAGES    = CIC_STAGES,
    parameter int BASE_LOG2 = BASE_RATIO_LOG,
    parameter int CODE_MAX  = CODE_TOP,
    parameter int OUT_W     = OUT_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    dump,
    input  logic                    flush,
    input  logic [2:0]              code,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int ACC_W = IN_W + STAGES * (BASE_LOG2 + CODE_MAX);

    logic signed [ACC_W-1:0] integ    [STAGES];
    logic signed [ACC_W-1:0] integ_nx [STAGES];
    logic signed [ACC_W-1:0] dly      [STAGES];
    logic signed [ACC_W-1:0] comb     [STAGES+1];
    logic [7:0]              shift;
    logic signed [ACC_W-1:0] half;
    logic signed [ACC_W-1:0] summed;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        integ_nx[0] = integ[0] + ACC_W'(din);
        for (int k = 1; k < STAGES; k++) begin
            integ_nx[k] = integ[k] + integ_nx[k-1];
        end
        comb[0] = integ_nx[STAGES-1];
        for (int k = 0; k < STAGES; k++) begin
            comb[k+1] = comb[k] - dly[k];
        end
        shift  = 8'(STAGES * (BASE_LOG2 + int'(code)));
        half   = ACC_W'(1) << (shift - 8'd1);
        summed = comb[STAGES] + half;
        scaled = summed >>> shift;
    end

    assign dout = scaled[OUT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                integ[k] <= '0;
                dly[k]   <= '0;
            end
        end else if (en) begin
            if (flush) begin
                for (int k = 0; k < STAGES; k++) begin
                    integ[k] <= '0;
                    dly[k]   <= '0;
                end
            end else begin
                for (int k = 0; k < STAGES; k++) begin
                    integ[k] <= integ_nx[k];
                end
                if (dump) begin
                    for (int k = 0; k < STAGES; k++) begin
                        dly[k] <= comb[k];
                    end
                end
            end
        end
    end

    // R5: the rounded result at a boundary fits the output width
    always_ff @(posedge clk) begin
        if (rst_n && en && dump) begin
            a_r5_round_fits: assert (scaled >= -(2 ** (OUT_W - 1)) &&
                                     scaled <= (2 ** (OUT_W - 1)) - 1);
        end
    end

endmodule

// File: rtl/ddc_tunable.sv
module ddc_tunable
    import ddc_pkg::*;
#(
    parameter int SAMPLE_W   = SAMPLE_BITS,
    parameter int LUT_ADDR_W = LUT_ADDR_BITS,
    parameter int COEF_W     = COEF_BITS,
    parameter int MIX_W      = MIX_BITS,
    parameter int STAGES     = CIC_STAGES,
    parameter int BASE_LOG2  = BASE_RATIO_LOG,
    parameter int CODE_MAX   = CODE_TOP,
    parameter int OUT_W      = OUT_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_data,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_addr,
    input  logic [31:0]                cfg_wdata,
    output logic                       out_valid,
    output logic signed [OUT_W-1:0]    out_i,
    output logic signed [OUT_W-1:0]    out_q
);
    localparam int CNT_W   = BASE_LOG2 + CODE_MAX;
    localparam int PHASE_W = PHASE_BITS;

    ddc_state_t state, state_nx;
    ddc_cfg_t   pend, act;

    logic [CNT_W-1:0]        dec_cnt;
    logic [CNT_W-1:0]        ratio_m1;
    logic [1:0]              prime_cnt;
    logic                    boundary;
    logic                    bw_change;
    logic [2:0]              bw_req;
    logic signed [COEF_W-1:0] sin_c, cos_c;
    logic signed [MIX_W-1:0]  mix  [2];
    logic signed [OUT_W-1:0]  cicq [2];

    assign ratio_m1  = (CNT_W'(1) << (BASE_LOG2 + int'(act.bw))) - CNT_W'(1);
    assign boundary  = in_valid && (dec_cnt == ratio_m1);
    assign bw_change = boundary && (pend.bw != act.bw);
    assign bw_req    = (cfg_wdata[2:0] > 3'(CODE_MAX)) ? 3'(CODE_MAX) : cfg_wdata[2:0];

    ddc_nco #(.PHASE_W(PHASE_W), .ADDR_W(LUT_ADDR_W), .COEF_W(COEF_W)) u_nco (
        .clk(clk), .rst_n(rst_n), .step_en(in_valid), .tune(act.tune),
        .sin_o(sin_c), .cos_o(cos_c)
    );

    ddc_mixer #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .MIX_W(MIX_W)) u_mix (
        .clk(clk), .rst_n(rst_n), .x(in_data), .cos_c(cos_c), .sin_c(sin_c),
        .mix_i(mix[0]), .mix_q(mix[1])
    );

    for (genvar p = 0; p < 2; p++) begin : g_path
        ddc_cic #(
            .IN_W(MIX_W), .STAGES(STAGES), .BASE_LOG2(BASE_LOG2),
            .CODE_MAX(CODE_MAX), .OUT_W(OUT_W)
        ) u_cic (
            .clk(clk), .rst_n(rst_n), .en(in_valid), .dump(boundary),
            .flush(bw_change), .code(act.bw), .din(mix[p]), .dout(cicq[p])
        );
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (in_valid) state_nx = ST_PRIME;
            ST_PRIME: if (boundary && !bw_change && prime_cnt == 2'd3) state_nx = ST_RUN;
            ST_RUN:   if (bw_change) state_nx = ST_PRIME;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= boundary && (state == ST_RUN);
            if (boundary && state == ST_RUN) begin
                out_i <= cicq[0];
                out_q <= act.lsb ? -cicq[1] : cicq[1];
            end
        end
    end

    // Settings, block counter and priming counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= '0;
            act       <= '0;
            dec_cnt   <= '0;
            prime_cnt <= '0;
        end else begin
            if (cfg_we) begin
                unique case (cfg_addr)
                    2'd0:    pend.tune <= cfg_wdata[PHASE_W-1:0];
                    2'd1:    pend.bw   <= bw_req;
                    2'd2:    pend.lsb  <= cfg_wdata[0];
                    default: ;
                endcase
            end
            if (state == ST_IDLE || boundary) act <= pend;
            if (in_valid) dec_cnt <= boundary ? '0 : dec_cnt + CNT_W'(1);
            if (state == ST_IDLE || bw_change) prime_cnt <= '0;
            else if (boundary && state == ST_PRIME) prime_cnt <= prime_cnt + 2'd1;
        end
    end

    // R6: output strobe is a lone pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6: a strobe always follows an accepted sample
    a_r6_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R9: nothing is emitted unless the controller was running
    a_r9_quiet_priming: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state) == ST_RUN);

    // R8: active settings only move at a boundary once samples flow
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !boundary) |=> $stable(act));

endmodule

// File: tb/tb_ddc_tunable.sv
module tb_ddc_tunable;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;
    localparam int MAX_FEED   = 30000;

    typedef struct packed {
        logic [29:0]        tune;
        logic [2:0]         bw;
        logic               lsb;
        logic signed [7:0]  p0, p1, p2, p3;
        logic signed [15:0] ei, eq;
    } vec_t;

    // tuning words: 2^28 = quarter rate, 2^29 = half rate, 3*2^28 = three quarters
    localparam vec_t VECS [NVEC] = '{
        '{30'd0,         3'd0, 1'b0, -8'sd40,  -8'sd40, -8'sd40,  -8'sd40,  -16'sd5080,  16'sd0},
        '{30'd0,         3'd0, 1'b0, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -16'sd16256, 16'sd0},
        '{30'd268435456, 3'd0, 1'b0, 8'sd100,  8'sd0,    -8'sd100, 8'sd0,    16'sd6350,   16'sd0},
        '{30'd268435456, 3'd0, 1'b0, 8'sd0,    8'sd100,  8'sd0,    -8'sd100, 16'sd0,      -16'sd6350},
        '{30'd268435456, 3'd0, 1'b1, 8'sd0,    8'sd100,  8'sd0,    -8'sd100, 16'sd0,      16'sd6350},
        '{30'd268435456, 3'd1, 1'b0, 8'sd100,  8'sd0,    -8'sd100, 8'sd0,    16'sd6350,   16'sd0},
        '{30'd805306368, 3'd0, 1'b0, 8'sd0,    8'sd100,  8'sd0,    -8'sd100, 16'sd0,      16'sd6350},
        '{30'd536870912, 3'd0, 1'b0, 8'sd50,   -8'sd50,  8'sd50,   -8'sd50,  16'sd6350,   16'sd0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [7:0]  in_data = '0;
    logic               cfg_we = 1'b0;
    logic [1:0]         cfg_addr = '0;
    logic [31:0]        cfg_wdata = '0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    int n_tests = 0;
    int n_fail  = 0;
    int sample_idx = 0;
    logic signed [7:0] pat [4];

    ddc_tunable dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input longint got, input longint exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        cfg_we   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sample_idx = 0;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_pat(input logic signed [7:0] a, input logic signed [7:0] b,
                           input logic signed [7:0] c, input logic signed [7:0] d);
        pat[0] = a; pat[1] = b; pat[2] = c; pat[3] = d;
    endtask

    // Feed samples until a strobe is seen; report samples fed and the result.
    task automatic run_to_output(input bit gaps, output int nfed,
                                 output logic signed [15:0] oi, output logic signed [15:0] oq);
        bit seen;
        nfed = 0;
        seen = 1'b0;
        oi = '0;
        oq = '0;
        while (!seen && nfed < MAX_FEED) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pat[sample_idx % 4];
            @(posedge clk);
            sample_idx++;
            nfed++;
            #2;
            if (out_valid) begin
                seen = 1'b1;
                oi = out_i;
                oq = out_q;
            end
            if (gaps) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (!seen) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6: no output after %0d samples, expected one", nfed);
        end
    endtask

    task automatic feed_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pat[sample_idx % 4];
            @(posedge clk);
            sample_idx++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int nfed;
        logic signed [15:0] gi, gq;

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 out_i in reset", out_i, 0);
        check("R1 out_q in reset", out_q, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after release", out_valid, 0);

        // Table of vectors
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            cfg_write(2'd0, {2'b00, VECS[v].tune});
            cfg_write(2'd1, {29'd0, VECS[v].bw});
            cfg_write(2'd2, {31'd0, VECS[v].lsb});
            set_pat(VECS[v].p0, VECS[v].p1, VECS[v].p2, VECS[v].p3);
            run_to_output(1'b0, nfed, gi, gq);
            check($sformatf("R9 vec%0d first output sample count", v), nfed, 5 * (64 << VECS[v].bw));
            check($sformatf("R2 R3 R4 R5 vec%0d I", v), gi, VECS[v].ei);
            check($sformatf("R4 R7 vec%0d Q", v), gq, VECS[v].eq);
        end

        // R2: idle cycles between samples leave the result unchanged
        do_reset();
        cfg_write(2'd0, 32'd268435456);
        cfg_write(2'd1, 32'd0);
        set_pat(8'sd100, 8'sd0, -8'sd100, 8'sd0);
        run_to_output(1'b1, nfed, gi, gq);
        check("R2 gapped sample count", nfed, 320);
        check("R2 gapped I", gi, 6350);
        check("R2 gapped Q", gq, 0);

        // R8: tuning change waits for a boundary
        do_reset();
        cfg_write(2'd0, 32'd0);
        cfg_write(2'd1, 32'd0);
        cfg_write(2'd3, 32'd7);
        set_pat(8'sd100, 8'sd100, 8'sd100, 8'sd100);
        run_to_output(1'b0, nfed, gi, gq);
        check("R8 steady I before change", gi, 12700);
        check("R8 address 3 ignored sample count", nfed, 320);
        feed_n(10);
        cfg_write(2'd0, 32'd268435456);
        run_to_output(1'b0, nfed, gi, gq);
        check("R6 spacing at code 0", nfed, 54);
        check("R8 old tuning through boundary", gi, 12700);
        for (int k = 0; k < 4; k++) run_to_output(1'b0, nfed, gi, gq);
        check("R8 new tuning I", gi, 0);
        check("R8 new tuning Q", gq, 0);

        // R9: bandwidth change flushes and re-primes
        do_reset();
        cfg_write(2'd0, 32'd0);
        cfg_write(2'd1, 32'd0);
        set_pat(-8'sd40, -8'sd40, -8'sd40, -8'sd40);
        run_to_output(1'b0, nfed, gi, gq);
        feed_n(5);
        cfg_write(2'd1, 32'd1);
        run_to_output(1'b0, nfed, gi, gq);
        check("R9 old block still emitted", nfed, 59);
        run_to_output(1'b0, nfed, gi, gq);
        check("R9 priming gap after change", nfed, 640);
        check("R9 value after change", gi, -5080);

        // R5 R6: widest ratio, code 7 clamps to 6
        do_reset();
        cfg_write(2'd0, 32'd0);
        cfg_write(2'd1, 32'd7);
        set_pat(-8'sd128, -8'sd128, -8'sd128, -8'sd128);
        run_to_output(1'b0, nfed, gi, gq);
        check("R5 code 7 acts as 6 first output", nfed, 20480);
        check("R5 ratio 4096 I", gi, -16256);
        run_to_output(1'b0, nfed, gi, gq);
        check("R6 spacing at code 6", nfed, 4096);

        // R1: reset while running
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 out_i cleared by reset", out_i, 0);
        check("R1 out_valid cleared by reset", out_valid, 0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule